// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Controller

This block is the digital core of a small serial EEPROM as seen from the memory side of the link. A host drives chip select, a shift clock and a serial data line. The block returns serial data and a matching output enable, which stands in for a high-impedance data pin. All three host inputs are resynchronized to a fast system clock. Work happens on the rising edges of the shift clock that the block detects. Each instruction starts with a 1 bit, then a two-bit command code, then an address field. A write-type command also carries a data field. The 1024-bit storage is a 64 x 16 register file, and a strap input picks whether the host sees it as 64 sixteen-bit words or 128 bytes.

Programming is self-timed, and a cycle counter takes the place of the millisecond write time. Single-word commands write once, at the start of the timed cycle. Array-wide commands sweep every word through the single write port during the cycle. While a cycle runs, the block reports ready/busy on the data output to a host that drops and raises chip select again. Programming is locked after reset until an unlock command arrives. Reads are always allowed.

Top module: `mw_eeprom_dev`

## Requirements
- R1: After reset the output enable is low and programming is locked. A WRITE issued before any unlock command leaves the stored word unchanged. Reset does not clear the stored data.
- R2: The block samples DI on rising shift-clock edges. Zeros that arrive before the first 1 are skipped. The first 1 is the start bit, followed by the two-bit command code and then the address, each sent MSB first.
- R3: READ (code 10) works as follows. After the rising edge that carries the last address bit, the output enable goes high and the output drives a single 0. Each of the next rising edges then drives one data bit, MSB first. The rising edge after the last data bit drops the output enable.
- R4: With the organization input high, addresses are 6 bits and data is 16 bits. With it low, addresses are 7 bits and data is 8 bits. In 8-bit mode, byte address bits 6..1 select the word, and bit 0 selects the high byte (1) or the low byte (0).
- R5: Command code 00 takes its meaning from the two most significant address bits: 11 unlocks programming, 00 locks it, 10 is erase-all and 01 is write-all. The lower address bits are still clocked in. While programming is locked, WRITE, ERASE, erase-all and write-all change nothing.
- R6: WRITE (code 01) replaces the addressed word or byte with the shifted-in data, with no erase needed first. The timed cycle begins after the last data bit.
- R7: ERASE (code 11) sets every bit of the addressed word (16-bit mode) or byte (8-bit mode) to 1. Its cycle begins once the address is complete.
- R8: Erase-all sets all 1024 bits to 1. Write-all loads every word with the data field, and in 8-bit mode the byte is copied into both halves of each word.
- R9: If chip select is dropped and then raised while a cycle runs, the output enable goes high and the output reads 0 while busy and 1 once the cycle is over. If chip select is raised only after the cycle has ended, the output enable stays low.
- R10: Any instruction begun while a programming cycle runs is ignored, even if the cycle ends before its last bit arrives.
- R11: Within four system clocks of chip select going low, the output enable drops and any partly received instruction is discarded. The next instruction then decodes normally.
- R12: READ returns stored data whether programming is locked or unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the shift clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| chip_sel_i | input | 1 | Chip select from the host, active high |
| shift_clk_i | input | 1 | Serial shift clock from the host |
| ser_in_i | input | 1 | Serial data from the host |
| wide_org_i | input | 1 | Organization strap: 1 = 64 x 16, 0 = 128 x 8 |
| ser_out_o | output | 1 | Serial read data or ready/busy status |
| ser_out_en_o | output | 1 | Drive enable for the serial output; low means high impedance |

## Verification
A wrong bit count or a stale command code in the decoder shows up on the very next READ. The dummy bit moves, the enable drops one shift-clock edge early or late, or a wrong word comes back. A faulty lock latch or timer stays hidden until a later read of the word it guarded, and that can be several instructions afterwards. This is why every programming step in the bench is followed at once by a read of the word it touched. Status and abort faults are visible within a few system clocks of a chip-select edge, so those checks sample shortly after the edge.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADR,
    ST_DAT,
    ST_RD,
    ST_STAT,
    ST_DONE
  } mw_state_e;

  // command codes, decoded from the two bits after the start bit
  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  // extended commands, taken from the top two address bits under OP_EXT
  localparam logic [1:0] EX_LOCK   = 2'b00;
  localparam logic [1:0] EX_WRALL  = 2'b01;
  localparam logic [1:0] EX_ERALL  = 2'b10;
  localparam logic [1:0] EX_UNLOCK = 2'b11;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int LEN   = 200,
  parameter int WORDS = 64,
  localparam int EW   = $clog2(LEN + 1),
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          sweep_i,
  output logic          busy_o,
  output logic          we_o,
  output logic [IW-1:0] idx_o
);

  logic [EW-1:0] el_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      el_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      el_q   <= '0;
    end else if (busy_q) begin
      if (el_q == EW'(LEN - 1)) begin
        busy_q <= 1'b0;
      end else begin
        el_q <= el_q + EW'(1);
      end
    end
  end

  // single-word commands write in the first cycle; array commands sweep one word per cycle
  assign we_o   = busy_q && (sweep_i ? (el_q < EW'(WORDS)) : (el_q == '0));
  assign idx_o  = el_q[IW-1:0];
  assign busy_o = busy_q;

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (rst) start_i |-> !busy_q);

endmodule

// File: rtl/mw_wordram.sv
module mw_wordram #(
  parameter int WORDS = 64,
  parameter int WIDTH = 16,
  localparam int AW   = $clog2(WORDS),
  localparam int HW   = WIDTH / 2
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [1:0]       be_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int h = 0; h < 2; h++) begin
      if (we_i && be_i[h]) begin
        mem[waddr_i][h*HW +: HW] <= wdata_i[h*HW +: HW];
      end
    end
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/mw_eeprom_dev.sv
module mw_eeprom_dev
  import mw_pkg::*;
#(
  parameter int WORDS       = 64,
  parameter int WIDTH       = 16,
  parameter int PROG_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic chip_sel_i,
  input  logic shift_clk_i,
  input  logic ser_in_i,
  input  logic wide_org_i,
  output logic ser_out_o,
  output logic ser_out_en_o
);

  localparam int AW16 = $clog2(WORDS);
  localparam int AW8  = AW16 + 1;
  localparam int HW   = WIDTH / 2;
  localparam int CW   = $clog2(WIDTH + 1);
  localparam int PLEN = (PROG_CYCLES < WORDS) ? WORDS : PROG_CYCLES;

  // input resynchronization and edge detection
  logic [2:0] sync_q;
  logic       cs_s, sck_s, di_s, cs_d, sck_d, cs_rise, sck_rise;

  mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({chip_sel_i, shift_clk_i, ser_in_i}),
    .q_o (sync_q)
  );

  assign {cs_s, sck_s, di_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d  <= 1'b0;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_rise  = cs_s & ~cs_d;
  assign sck_rise = sck_s & ~sck_d;

  // instruction state
  mw_state_e        st_q;
  logic [CW-1:0]    cnt_q;
  logic [1:0]       opc_q;
  logic [AW8-1:0]   adr_q;
  logic [WIDTH-2:0] dat_q;
  logic             x16_q, wen_q;

  // programming request
  logic             go_q, sweep_q;
  logic [1:0]       wbe_q;
  logic [WIDTH-1:0] wdata_q;
  logic [AW16-1:0]  waddr_q;

  // decode helpers
  logic [AW8-1:0]   adr_n;
  logic [WIDTH-1:0] dat_n, dat_rep, rd_q, rd_top, rd_mask;
  logic [CW-1:0]    aw_last, dw_last, dw_full;
  logic [1:0]       ext_n, be_n, be_q;
  logic [AW16-1:0]  wa_n, wa_q, tmr_idx, ram_waddr;
  logic             rd_bit, tmr_busy, tmr_we;

  assign adr_n   = {adr_q[AW8-2:0], di_s};
  assign dat_n   = {dat_q, di_s};
  assign aw_last = x16_q ? CW'(AW16 - 1) : CW'(AW8 - 1);
  assign dw_last = x16_q ? CW'(WIDTH - 1) : CW'(HW - 1);
  assign dw_full = x16_q ? CW'(WIDTH) : CW'(HW);
  assign ext_n   = x16_q ? adr_n[AW16-1 -: 2] : adr_n[AW8-1 -: 2];
  assign wa_n    = x16_q ? adr_n[AW16-1:0] : adr_n[AW8-1:1];
  assign wa_q    = x16_q ? adr_q[AW16-1:0] : adr_q[AW8-1:1];
  assign be_n    = x16_q ? 2'b11 : (adr_n[0] ? 2'b10 : 2'b01);
  assign be_q    = x16_q ? 2'b11 : (adr_q[0] ? 2'b10 : 2'b01);
  assign dat_rep = x16_q ? dat_n : {dat_n[HW-1:0], dat_n[HW-1:0]};

  // read path: selected word or byte aligned to the MSB, picked bit by a walking mask
  assign rd_top  = x16_q ? rd_q
                         : {(adr_q[0] ? rd_q[WIDTH-1:HW] : rd_q[HW-1:0]), {HW{1'b0}}};
  assign rd_mask = {1'b1, {(WIDTH-1){1'b0}}} >> cnt_q;
  assign rd_bit  = |(rd_top & rd_mask);

  mw_prog_timer #(.LEN(PLEN), .WORDS(WORDS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (go_q),
    .sweep_i (sweep_q),
    .busy_o  (tmr_busy),
    .we_o    (tmr_we),
    .idx_o   (tmr_idx)
  );

  assign ram_waddr = sweep_q ? tmr_idx : waddr_q;

  mw_wordram #(.WORDS(WORDS), .WIDTH(WIDTH)) u_ram (
    .clk     (clk),
    .we_i    (tmr_we),
    .be_i    (sweep_q ? 2'b11 : wbe_q),
    .waddr_i (ram_waddr),
    .wdata_i (wdata_q),
    .raddr_i (wa_q),
    .rdata_o (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      cnt_q        <= '0;
      opc_q        <= '0;
      adr_q        <= '0;
      dat_q        <= '0;
      x16_q        <= 1'b0;
      wen_q        <= 1'b0;
      go_q         <= 1'b0;
      sweep_q      <= 1'b0;
      wbe_q        <= '0;
      wdata_q      <= '0;
      waddr_q      <= '0;
      ser_out_o    <= 1'b0;
      ser_out_en_o <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (!cs_s) begin
        st_q         <= ST_IDLE;
        ser_out_o    <= 1'b0;
        ser_out_en_o <= 1'b0;
      end else if (cs_rise) begin
        ser_out_o    <= 1'b0;
        ser_out_en_o <= tmr_busy;
        st_q         <= tmr_busy ? ST_STAT : ST_IDLE;
      end else begin
        case (st_q)
          ST_STAT: ser_out_o <= !tmr_busy;
          ST_IDLE: if (sck_rise && di_s && !tmr_busy) begin
            st_q  <= ST_OPC;
            cnt_q <= '0;
            adr_q <= '0;
            x16_q <= wide_org_i;
          end
          ST_OPC: if (sck_rise) begin
            opc_q <= {opc_q[0], di_s};
            if (cnt_q != '0) begin
              st_q  <= ST_ADR;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_ADR: if (sck_rise) begin
            adr_q <= adr_n;
            if (cnt_q == aw_last) begin
              cnt_q <= '0;
              case (opc_q)
                OP_READ: begin
                  st_q         <= ST_RD;
                  ser_out_o    <= 1'b0;
                  ser_out_en_o <= 1'b1;
                end
                OP_WRITE: st_q <= ST_DAT;
                OP_ERASE: begin
                  st_q    <= ST_DONE;
                  go_q    <= wen_q;
                  sweep_q <= 1'b0;
                  wbe_q   <= be_n;
                  wdata_q <= '1;
                  waddr_q <= wa_n;
                end
                default: begin
                  st_q <= ST_DONE;
                  case (ext_n)
                    EX_UNLOCK: wen_q <= 1'b1;
                    EX_LOCK:   wen_q <= 1'b0;
                    EX_ERALL: begin
                      go_q    <= wen_q;
                      sweep_q <= 1'b1;
                      wdata_q <= '1;
                    end
                    default: st_q <= ST_DAT;
                  endcase
                end
              endcase
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_DAT: if (sck_rise) begin
            dat_q <= dat_n[WIDTH-2:0];
            if (cnt_q == dw_last) begin
              st_q    <= ST_DONE;
              go_q    <= wen_q;
              sweep_q <= (opc_q == OP_EXT);
              wbe_q   <= be_q;
              wdata_q <= dat_rep;
              waddr_q <= wa_q;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          ST_RD: if (sck_rise) begin
            if (cnt_q == dw_full) begin
              st_q         <= ST_DONE;
              ser_out_o    <= 1'b0;
              ser_out_en_o <= 1'b0;
            end else begin
              ser_out_o <= rd_bit;
              cnt_q     <= cnt_q + CW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11
  oe_off_chk: assert property (@(posedge clk) disable iff (rst) !cs_s |=> !ser_out_en_o);

  // R5
  prog_needs_en_chk: assert property (@(posedge clk) disable iff (rst) tmr_we |-> wen_q);

  // R10
  read_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RD) |-> !tmr_busy);

endmodule

// File: tb/mw_eeprom_dev_tb.sv
module mw_eeprom_dev_tb_top;

  localparam int HALF = 10;
  localparam int PROG = 200;
  localparam int SETTLE = PROG + 60;
  localparam int NV = 33;

  // entry: req[31:28] kind[27:26] opc[25:24] org[23] addr[22:16] data[15:0]
  // kind 0 = command, 1 = command with data, 2 = read and compare
  localparam logic [31:0] VEC [NV] = '{
    {4'd5,  2'd0, 2'b00, 1'b1, 7'h30, 16'h0000},  // R5 unlock
    {4'd8,  2'd0, 2'b00, 1'b1, 7'h20, 16'h0000},  // R8 erase-all
    {4'd8,  2'd2, 2'b10, 1'b1, 7'h00, 16'hFFFF},  // R8
    {4'd8,  2'd2, 2'b10, 1'b1, 7'h3F, 16'hFFFF},  // R8
    {4'd5,  2'd0, 2'b00, 1'b0, 7'h00, 16'h0000},  // R5 lock, byte mode
    {4'd5,  2'd1, 2'b01, 1'b1, 7'h05, 16'h1234},  // R5 locked write
    {4'd5,  2'd2, 2'b10, 1'b1, 7'h05, 16'hFFFF},  // R5 R12
    {4'd5,  2'd0, 2'b00, 1'b0, 7'h60, 16'h0000},  // R5 unlock, byte mode
    {4'd6,  2'd1, 2'b01, 1'b1, 7'h05, 16'h1234},  // R6
    {4'd6,  2'd2, 2'b10, 1'b1, 7'h05, 16'h1234},  // R6
    {4'd6,  2'd1, 2'b01, 1'b1, 7'h05, 16'h00F0},  // R6 no erase first
    {4'd6,  2'd2, 2'b10, 1'b1, 7'h05, 16'h00F0},  // R6
    {4'd4,  2'd1, 2'b01, 1'b1, 7'h03, 16'hA55A},  // R4
    {4'd4,  2'd2, 2'b10, 1'b0, 7'h06, 16'h005A},  // R4 low byte
    {4'd4,  2'd2, 2'b10, 1'b0, 7'h07, 16'h00A5},  // R4 high byte
    {4'd4,  2'd1, 2'b01, 1'b0, 7'h07, 16'h003C},  // R4 byte write
    {4'd4,  2'd2, 2'b10, 1'b1, 7'h03, 16'h3C5A},  // R4
    {4'd7,  2'd0, 2'b11, 1'b1, 7'h03, 16'h0000},  // R7 word erase
    {4'd7,  2'd2, 2'b10, 1'b1, 7'h03, 16'hFFFF},  // R7
    {4'd7,  2'd0, 2'b11, 1'b0, 7'h0A, 16'h0000},  // R7 byte erase
    {4'd7,  2'd2, 2'b10, 1'b1, 7'h05, 16'h00FF},  // R7
    {4'd8,  2'd1, 2'b00, 1'b1, 7'h10, 16'hC3C3},  // R8 write-all
    {4'd8,  2'd2, 2'b10, 1'b1, 7'h00, 16'hC3C3},  // R8
    {4'd8,  2'd2, 2'b10, 1'b1, 7'h3F, 16'hC3C3},  // R8
    {4'd8,  2'd1, 2'b00, 1'b0, 7'h20, 16'h0081},  // R8 byte write-all
    {4'd8,  2'd2, 2'b10, 1'b1, 7'h14, 16'h8181},  // R8
    {4'd5,  2'd0, 2'b00, 1'b1, 7'h00, 16'h0000},  // R5 lock
    {4'd5,  2'd0, 2'b00, 1'b1, 7'h20, 16'h0000},  // R5 locked erase-all
    {4'd5,  2'd2, 2'b10, 1'b1, 7'h14, 16'h8181},  // R5
    {4'd12, 2'd2, 2'b10, 1'b0, 7'h7F, 16'h0081},  // R12 read while locked
    {4'd5,  2'd0, 2'b00, 1'b1, 7'h30, 16'h0000},  // R5 unlock
    {4'd6,  2'd1, 2'b01, 1'b1, 7'h3F, 16'hBEEF},  // R6
    {4'd6,  2'd2, 2'b10, 1'b1, 7'h3F, 16'hBEEF}   // R6
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, sck = 1'b0, sdi = 1'b0, org = 1'b1;
  logic sdo, sdo_en;
  logic samp_do, samp_en;
  int   n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  mw_eeprom_dev #(.PROG_CYCLES(PROG)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .chip_sel_i   (sel),
    .shift_clk_i  (sck),
    .ser_in_i     (sdi),
    .wide_org_i   (org),
    .ser_out_o    (sdo),
    .ser_out_en_o (sdo_en)
  );

  task automatic chk(input logic ok, input int req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one shift-clock period; outputs sampled just before the rising edge
  task automatic tick(input logic b);
    sdi = b;
    wait_clk(HALF);
    samp_do = sdo;
    samp_en = sdo_en;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic begin_sel();
    sel = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic end_sel();
    sel = 1'b0;
    sdi = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic send_head(input logic x16, input logic [1:0] opc, input logic [6:0] a);
    tick(1'b1);
    tick(opc[1]);
    tick(opc[0]);
    for (int i = (x16 ? 5 : 6); i >= 0; i--) tick(a[i]);
  endtask

  task automatic send_cmd(input logic x16, input logic [1:0] opc, input logic [6:0] a,
                          input logic with_data, input logic [15:0] d);
    org = x16;
    begin_sel();
    send_head(x16, opc, a);
    if (with_data) begin
      for (int i = (x16 ? 15 : 7); i >= 0; i--) tick(d[i]);
    end
    end_sel();
  endtask

  task automatic do_read(input logic x16, input logic [6:0] a, input int pre0,
                         output logic [15:0] val, output logic frame_ok);
    org = x16;
    val = '0;
    frame_ok = 1'b1;
    begin_sel();
    for (int i = 0; i < pre0; i++) tick(1'b0);
    send_head(x16, 2'b10, a);
    for (int j = 0; j <= (x16 ? 16 : 8); j++) begin
      tick(1'b0);
      if (!samp_en) frame_ok = 1'b0;
      if (j == 0) begin
        if (samp_do !== 1'b0) frame_ok = 1'b0;
      end else begin
        val = {val[14:0], samp_do};
      end
    end
    if (sdo_en !== 1'b0) frame_ok = 1'b0;
    end_sel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic        fr;
    wait_clk(6);
    rst = 1'b0;
    wait_clk(4);
    // R1 output released after reset
    chk(sdo_en == 1'b0, 1, {15'd0, sdo_en}, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][27:26] == 2'd2) begin
        do_read(VEC[k][23], VEC[k][22:16], 0, v, fr);
        chk(fr, 3, {15'd0, fr}, 16'h0001);          // R3 dummy bit and enable window
        chk(v == VEC[k][15:0], int'(VEC[k][31:28]), v, VEC[k][15:0]);
      end else begin
        send_cmd(VEC[k][23], VEC[k][25:24], VEC[k][22:16], VEC[k][26], VEC[k][15:0]);
        wait_clk(SETTLE);
      end
    end

    // R9 status while busy, then ready
    send_cmd(1'b1, 2'b01, 7'h08, 1'b1, 16'h5555);
    begin_sel();
    chk(sdo_en && !sdo, 9, {14'd0, sdo_en, sdo}, 16'h0002);
    wait_clk(SETTLE);
    chk(sdo_en && sdo, 9, {14'd0, sdo_en, sdo}, 16'h0003);
    end_sel();
    begin_sel();
    chk(!sdo_en, 9, {15'd0, sdo_en}, 16'h0000);     // R9 no status after cycle end
    end_sel();
    do_read(1'b1, 7'h08, 0, v, fr);
    chk(v == 16'h5555 && fr, 6, v, 16'h5555);

    // R10 instruction sent during a programming cycle is dropped
    send_cmd(1'b1, 2'b01, 7'h09, 1'b1, 16'h0F0F);
    send_cmd(1'b1, 2'b01, 7'h0A, 1'b1, 16'h1234);
    wait_clk(SETTLE);
    do_read(1'b1, 7'h0A, 0, v, fr);
    chk(v == 16'h8181 && fr, 10, v, 16'h8181);
    do_read(1'b1, 7'h09, 0, v, fr);
    chk(v == 16'h0F0F && fr, 10, v, 16'h0F0F);

    // R11 chip select low in the middle of a read
    org = 1'b1;
    begin_sel();
    send_head(1'b1, 2'b10, 7'h0B);
    for (int i = 0; i < 5; i++) tick(1'b0);
    sel = 1'b0;
    wait_clk(5);
    chk(!sdo_en, 11, {15'd0, sdo_en}, 16'h0000);
    wait_clk(HALF);
    // R11 partial write discarded, next instruction decodes
    begin_sel();
    tick(1'b1); tick(1'b0); tick(1'b1); tick(1'b0); tick(1'b0); tick(1'b1);
    end_sel();
    wait_clk(SETTLE);
    do_read(1'b1, 7'h0B, 0, v, fr);
    chk(v == 16'h8181 && fr, 11, v, 16'h8181);

    // R2 leading zeros before the start bit
    do_read(1'b1, 7'h0B, 3, v, fr);
    chk(v == 16'h8181 && fr, 2, v, 16'h8181);
    do_read(1'b0, 7'h17, 2, v, fr);
    chk(v == 16'h0081 && fr, 2, v, 16'h0081);

    // R1 reset locks programming but keeps data
    rst = 1'b1;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    chk(!sdo_en, 1, {15'd0, sdo_en}, 16'h0000);
    send_cmd(1'b1, 2'b01, 7'h3F, 1'b1, 16'h0000);
    wait_clk(SETTLE);
    do_read(1'b1, 7'h3F, 0, v, fr);
    chk(v == 16'hBEEF && fr, 1, v, 16'hBEEF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule